// File: doc/BRIEF.md
# Coprocessor RAM byte-lane bridge

This block lets a 16-bit big-endian host processor reach the 8 KiB byte-wide work RAM of an 8-bit coprocessor. The host presents a word address, two byte-lane strobes, write data and a request strobe. The bus controller supplies two status flags: one says the coprocessor currently owns its bus, the other says the coprocessor is held in reset. A host access reaches the RAM only when both flags are low.

The RAM is stored as two synchronous byte banks. One bank holds the even byte addresses and the other holds the odd ones, so a word read fetches both bytes in a single cycle. Word address n covers byte addresses 2n and 2n+1, which spans the whole coprocessor range 0x0000 to 0x1FFF. Writes follow lane-specific rules: a full-word write keeps only its upper byte. A blocked access does not hang. Its write is dropped, and its read still returns data, one clock later, carrying a fixed filler word.

Top module: `cpram_bridge`

## Requirements
- R1: After reset `host_rvalid` is 0 and `host_rdata` equals the filler word 16'hFFFF.
- R2: An unblocked read of word address n (host_req=1, host_we=0) returns the byte at byte address 2n on bits 15:8 and the byte at 2n+1 on bits 7:0. This happens in the cycle after the request, whatever `host_lanes` holds.
- R3: An unblocked write with `host_lanes`=2'b10 (bit 1 is the upper lane) stores `host_wdata[15:8]` at byte 2n and leaves byte 2n+1 unchanged.
- R4: An unblocked write with `host_lanes`=2'b01 (bit 0 is the lower lane) stores `host_wdata[7:0]` at byte 2n+1 and leaves byte 2n unchanged.
- R5: An unblocked write with `host_lanes`=2'b11 stores only `host_wdata[15:8]` at byte 2n. Bits 7:0 are discarded and byte 2n+1 is unchanged.
- R6: A write with `host_lanes`=2'b00 changes no byte.
- R7: A write made while `cop_bus_owned` or `cop_held_reset` is 1 in the request cycle changes no byte.
- R8: A read made while `cop_bus_owned` or `cop_held_reset` is 1 in the request cycle returns 16'hFFFF in the following cycle.
- R9: `host_rvalid` is 1 in exactly the cycle after each read request, blocked or not. It is 0 after a write request or an idle cycle.
- R10: A read issued in the cycle right after a write to the same word returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access strobe, one access per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_waddr | input | 12 | Word address n (bytes 2n and 2n+1) |
| host_lanes | input | 2 | Byte-lane strobes: bit 1 = bits 15:8, bit 0 = bits 7:0 |
| host_wdata | input | 16 | Write data, big-endian |
| cop_bus_owned | input | 1 | Coprocessor owns its bus; host access blocked |
| cop_held_reset | input | 1 | Coprocessor held in reset; host access blocked |
| host_rdata | output | 16 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read response strobe, one cycle after a read request |

## Verification
Two functions can act in the same cycle: a host request and a change of the ownership or reset flags. The block must decide from the flag values at the request edge alone. The bench flips the flags at random in the same cycle that requests are driven. It judges each access by the flags driven with that request: a read is expected to return filler or RAM data, and a write is expected to change the model or be dropped. Write-then-read pairs on a small address window also place a bank write and a dependent read in adjacent cycles, which exercises R10.

// File: rtl/cpram_pkg.sv
package cpram_pkg;

  typedef enum logic [1:0] {
    LANE_NONE = 2'b00,
    LANE_LO   = 2'b01,
    LANE_HI   = 2'b10,
    LANE_BOTH = 2'b11
  } lane_sel_e;

  typedef struct packed {
    logic rd;
    logic blocked;
  } rd_tag_t;

  localparam int unsigned BANK_EVEN = 0;
  localparam int unsigned BANK_ODD  = 1;
  localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/cpram_gate.sv
module cpram_gate
  import cpram_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                               req,
  input  logic                               we,
  input  logic [1:0]                         lanes,
  input  logic [2*BYTE_W-1:0]                wdata,
  input  logic                               owned,
  input  logic                               held,
  output logic [NUM_BANKS-1:0]               bank_we,
  output logic [NUM_BANKS-1:0][BYTE_W-1:0]   bank_wd,
  output logic                               rd_req,
  output logic                               rd_go,
  output logic                               open
);

  lane_sel_e lane;
  logic      wr_ok;

  assign lane  = lane_sel_e'(lanes);
  assign open  = !owned && !held;
  assign wr_ok = req && we && open;

  always_comb begin
    bank_we = '0;
    unique case (lane)
      LANE_HI, LANE_BOTH: bank_we[BANK_EVEN] = wr_ok;
      LANE_LO:            bank_we[BANK_ODD]  = wr_ok;
      default:            bank_we            = '0;
    endcase
  end

  assign bank_wd[BANK_EVEN] = wdata[2*BYTE_W-1:BYTE_W];
  assign bank_wd[BANK_ODD]  = wdata[BYTE_W-1:0];

  assign rd_req = req && !we;
  assign rd_go  = rd_req && open;

endmodule

// File: rtl/cpram_bank.sv
module cpram_bank #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/cpram_rdfmt.sv
module cpram_rdfmt
  import cpram_pkg::*;
#(
  parameter int              BYTE_W      = 8,
  parameter logic [2*BYTE_W-1:0] FILL    = 16'hFFFF,
  parameter bit              MIRROR_READ = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_req,
  input  logic                  rd_open,
  input  logic [BYTE_W-1:0]     even_q,
  input  logic [BYTE_W-1:0]     odd_q,
  output logic [2*BYTE_W-1:0]   rdata,
  output logic                  rvalid
);

  rd_tag_t tag_q;
  logic [BYTE_W-1:0] low_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q.rd      <= 1'b0;
      tag_q.blocked <= 1'b1;
    end else begin
      tag_q.rd <= rd_req;
      if (rd_req) tag_q.blocked <= !rd_open;
    end
  end

  assign low_byte = MIRROR_READ ? even_q : odd_q;
  assign rdata    = tag_q.blocked ? FILL : {even_q, low_byte};
  assign rvalid   = tag_q.rd;

endmodule

// File: rtl/cpram_bridge.sv
module cpram_bridge
  import cpram_pkg::*;
#(
  parameter int              ADDR_W      = 12,
  parameter int              BYTE_W      = 8,
  parameter logic [2*BYTE_W-1:0] FILL    = 16'hFFFF,
  parameter bit              MIRROR_READ = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  host_req,
  input  logic                  host_we,
  input  logic [ADDR_W-1:0]     host_waddr,
  input  logic [1:0]            host_lanes,
  input  logic [2*BYTE_W-1:0]   host_wdata,
  input  logic                  cop_bus_owned,
  input  logic                  cop_held_reset,
  output logic [2*BYTE_W-1:0]   host_rdata,
  output logic                  host_rvalid
);

  logic [NUM_BANKS-1:0]             bank_we;
  logic [NUM_BANKS-1:0][BYTE_W-1:0] bank_wd;
  logic [NUM_BANKS-1:0][BYTE_W-1:0] bank_q;
  logic                             rd_req;
  logic                             rd_go;
  logic                             open;

  cpram_gate #(.BYTE_W(BYTE_W)) u_gate (
    .req     (host_req),
    .we      (host_we),
    .lanes   (host_lanes),
    .wdata   (host_wdata),
    .owned   (cop_bus_owned),
    .held    (cop_held_reset),
    .bank_we (bank_we),
    .bank_wd (bank_wd),
    .rd_req  (rd_req),
    .rd_go   (rd_go),
    .open    (open)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    cpram_bank #(.AW(ADDR_W), .DW(BYTE_W)) u_bank (
      .clk   (clk),
      .we    (bank_we[g]),
      .re    (rd_go),
      .addr  (host_waddr),
      .wdata (bank_wd[g]),
      .rdata (bank_q[g])
    );
  end

  cpram_rdfmt #(.BYTE_W(BYTE_W), .FILL(FILL), .MIRROR_READ(MIRROR_READ)) u_fmt (
    .clk     (clk),
    .rst     (rst),
    .rd_req  (rd_req),
    .rd_open (open),
    .even_q  (bank_q[BANK_EVEN]),
    .odd_q   (bank_q[BANK_ODD]),
    .rdata   (host_rdata),
    .rvalid  (host_rvalid)
  );

  // R9
  rvalid_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    (host_req && !host_we) |=> host_rvalid);

  // R9
  rvalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(host_req && !host_we) |=> !host_rvalid);

  // R8
  blocked_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (host_req && !host_we && (cop_bus_owned || cop_held_reset)) |=> (host_rdata == FILL));

  // R7
  blocked_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cop_bus_owned || cop_held_reset) |-> (bank_we == '0));

  // R5
  word_write_lower_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (host_req && host_we && host_lanes == 2'b11) |-> !bank_we[BANK_ODD]);

  // R6
  no_lane_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (host_lanes == 2'b00) |-> (bank_we == '0));

  // R2
  read_no_bank_write_chk: assert property (@(posedge clk) disable iff (rst)
    (host_req && !host_we) |-> (bank_we == '0));

endmodule

// File: tb/tb_cpram_bridge.sv
`timescale 1ns/1ps
module tb_cpram_bridge;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [11:0] host_waddr = '0;
  logic [1:0]  host_lanes = '0;
  logic [15:0] host_wdata = '0;
  logic        cop_bus_owned = 1'b0;
  logic        cop_held_reset = 1'b0;
  logic [15:0] host_rdata;
  logic        host_rvalid;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [7:0]  model_mem [0:8191];
  bit          exp_vld = 1'b0;
  logic [15:0] exp_data = '0;
  string       exp_tag = "R2";
  int unsigned seed_val;

  always #5 clk = ~clk;

  cpram_bridge dut (
    .clk            (clk),
    .rst            (rst),
    .host_req       (host_req),
    .host_we        (host_we),
    .host_waddr     (host_waddr),
    .host_lanes     (host_lanes),
    .host_wdata     (host_wdata),
    .cop_bus_owned  (cop_bus_owned),
    .cop_held_reset (cop_held_reset),
    .host_rdata     (host_rdata),
    .host_rvalid    (host_rvalid)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] model_read(input int a, input bit blocked);
    if (blocked) return 16'hFFFF;
    return {model_mem[2*a], model_mem[2*a+1]};
  endfunction

  task automatic model_write(input int a, input bit [1:0] ln, input bit [15:0] d);
    case (ln)
      2'b10, 2'b11: model_mem[2*a]   = d[15:8];
      2'b01:        model_mem[2*a+1] = d[7:0];
      default: ;
    endcase
  endtask

  task automatic step(input bit r, input bit w, input int a, input bit [1:0] ln,
                      input bit [15:0] d, input bit own, input bit hold, input string tag);
    bit blocked;
    @(negedge clk);
    check("R9", {15'd0, host_rvalid}, {15'd0, exp_vld});
    if (exp_vld) check(exp_tag, host_rdata, exp_data);
    host_req = r; host_we = w; host_waddr = a[11:0]; host_lanes = ln;
    host_wdata = d; cop_bus_owned = own; cop_held_reset = hold;
    blocked = own || hold;
    exp_vld = r && !w;
    exp_tag = tag;
    if (exp_vld) exp_data = model_read(a, blocked);
    if (r && w && !blocked) model_write(a, ln, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    seed_val = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", {15'd0, host_rvalid}, 16'd0);
    check("R1", host_rdata, 16'hFFFF);

    // prefill every byte through the two single-lane writes
    for (int a = 0; a < 4096; a++) begin
      step(1, 1, a, 2'b10, {8'(a * 7 + 3), 8'h00}, 0, 0, "R3");
      step(1, 1, a, 2'b01, {8'h00, 8'(a * 13 + 5)}, 0, 0, "R4");
    end
    step(1, 0, 0, 2'b11, 16'h0, 0, 0, "R2");
    step(1, 0, 4095, 2'b00, 16'h0, 0, 0, "R2");
    step(1, 0, 100, 2'b01, 16'h0, 0, 0, "R2");

    // R3 upper-lane write, R10 read right after
    step(1, 1, 5, 2'b10, 16'hA1B2, 0, 0, "R3");
    step(1, 0, 5, 2'b00, 16'h0, 0, 0, "R3");
    // R4 lower-lane write
    step(1, 1, 6, 2'b01, 16'hC3D4, 0, 0, "R4");
    step(1, 0, 6, 2'b00, 16'h0, 0, 0, "R4");
    // R5 full-word write keeps only the upper byte
    step(1, 1, 7, 2'b11, 16'hE5F6, 0, 0, "R5");
    step(1, 0, 7, 2'b11, 16'h0, 0, 0, "R5");
    // R6 no lane selected
    step(1, 1, 8, 2'b00, 16'h1234, 0, 0, "R6");
    step(1, 0, 8, 2'b00, 16'h0, 0, 0, "R6");
    // R7 blocked writes
    step(1, 1, 9, 2'b11, 16'h5566, 1, 0, "R7");
    step(1, 1, 9, 2'b01, 16'h7788, 0, 1, "R7");
    step(1, 0, 9, 2'b00, 16'h0, 0, 0, "R7");
    // R8 blocked reads
    step(1, 0, 10, 2'b11, 16'h0, 1, 0, "R8");
    step(1, 0, 10, 2'b11, 16'h0, 0, 1, "R8");
    step(1, 0, 10, 2'b11, 16'h0, 1, 1, "R8");
    step(1, 0, 10, 2'b11, 16'h0, 0, 0, "R2");
    // R10 boundaries, back-to-back write then read
    step(1, 1, 4095, 2'b10, 16'h9A00, 0, 0, "R10");
    step(1, 0, 4095, 2'b00, 16'h0, 0, 0, "R10");
    step(1, 1, 0, 2'b01, 16'h00BC, 0, 0, "R10");
    step(1, 0, 0, 2'b00, 16'h0, 0, 0, "R10");
    // R9 idle cycles after a read and after a write
    step(0, 0, 0, 2'b00, 16'h0, 0, 0, "R9");
    step(1, 1, 3, 2'b10, 16'h4400, 0, 0, "R9");
    step(0, 1, 3, 2'b10, 16'h0, 0, 0, "R9");

    // constrained random mix, flags flipping alongside requests
    for (int i = 0; i < 5000; i++) begin
      int a;
      bit r, w, own, hold;
      bit [1:0] ln;
      a    = ($urandom % 4 == 0) ? int'($urandom % 4096) : int'($urandom % 16);
      r    = ($urandom % 5) != 0;
      w    = $urandom % 2;
      ln   = 2'($urandom % 4);
      own  = ($urandom % 6) == 0;
      hold = ($urandom % 7) == 0;
      step(r, w, a, ln, 16'($urandom), own, hold, (own || hold) ? "R8" : "R2");
    end
    step(0, 0, 0, 2'b00, 16'h0, 0, 0, "R9");
    step(0, 0, 0, 2'b00, 16'h0, 0, 0, "R9");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule